// File: doc/BRIEF.md
# Integer ALU Operand and Flag Unit

This block is the integer add, subtract and bitwise stage of a 64-bit RISC execution pipe. Each valid request names an operation, an operand format and three register indices. The unit builds the first operand from a register or the stack pointer. It builds the second operand from an immediate, from a register shifted by an immediate amount, or from a register that is extended and then shifted left. It then produces the result and, when asked to, a fresh set of condition flags.

Register reads are combinational. The read addresses follow the request indices, and the register file returns data in the same cycle. The stack pointer lives outside the unit. It is presented on its own input and updated through its own write port. Index 31 is never taken from the register file. Depending on the operand role, the operation class and whether flags are set, it stands for either the stack pointer or a constant zero that swallows writes.

The result, the write strobes and the flags are all registered, and they appear one cycle after the request strobe.

Top module: `alu_opflag_unit`

## Requirements
- R1: With format code 0 or 3 (immediate), the second operand equals `in_imm` unchanged.
- R2: With format code 1 (shifted register), the second operand is the Rm value shifted by `in_shift_amt` (0 to 63). The shift type is chosen by `in_shift_type`: 0 is logical left, 1 is logical right, 2 is arithmetic right and 3 is rotate right.
- R3: With format code 2 (extended register), the Rm value is first extended and then shifted left by `in_ext_shift`. In `in_ext_type`, bit 2 selects sign extension (1) or zero extension (0), and bits 1:0 select the source width (0 byte, 1 halfword, 2 word, 3 doubleword). Shift amounts above 4 act as 4.
- R4: A first-operand index of 31 reads zero when the operation is logical or the format is shifted register. Otherwise it reads `sp_rd_data`.
- R5: A second-operand index of 31 reads zero in both register formats.
- R6: A destination index of 31 writes nothing when flags are set or the format is shifted register. Otherwise it writes the stack pointer, through `sp_wr_en`/`sp_wr_data`. Any other destination index writes the register file at that index. At most one write strobe is high in any cycle.
- R7: The operation codes are 0 add, 1 subtract (first minus second), 2 AND, 3 OR and 4 XOR. Codes 5 to 7 behave as add.
- R8: For a flag-setting add, C is 1 exactly when the unsigned result is below the first operand. V is bit 63 of (result XOR first) AND NOT (first XOR second).
- R9: For a flag-setting subtract, C is 1 exactly when the first operand is unsigned greater than or equal to the second. V is bit 63 of (result XOR first) AND (first XOR second).
- R10: When flags are set, N is result bit 63 and Z is 1 exactly when the result is zero. In `flags_nzcv`, bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V.
- R11: A flag-setting AND, OR or XOR clears C and V.
- R12: The result and write strobes follow a valid request by exactly one cycle, together with `out_valid`. The flags keep their value in every cycle without a valid flag-setting request.
- R13: After reset, `out_valid`, both write strobes and `flags_nzcv` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code |
| in_form | input | 2 | Second-operand format |
| in_setflags | input | 1 | Update the flags |
| in_rn_idx | input | 5 | First-operand register index |
| in_rm_idx | input | 5 | Second-operand register index |
| in_rd_idx | input | 5 | Destination index |
| in_imm | input | 64 | Immediate operand |
| in_shift_type | input | 2 | Shift type for the shifted-register format |
| in_shift_amt | input | 6 | Shift amount for the shifted-register format |
| in_ext_type | input | 3 | Extension kind and source width |
| in_ext_shift | input | 3 | Left shift applied after extension |
| rf_rn_addr | output | 5 | Register file read address, first operand |
| rf_rn_data | input | 64 | Register file read data, first operand |
| rf_rm_addr | output | 5 | Register file read address, second operand |
| rf_rm_data | input | 64 | Register file read data, second operand |
| sp_rd_data | input | 64 | Current stack pointer |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_addr | output | 5 | Register file write index |
| rf_wr_data | output | 64 | Register file write data |
| sp_wr_en | output | 1 | Stack pointer write strobe |
| sp_wr_data | output | 64 | Stack pointer write data |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Registered result |
| flags_nzcv | output | 4 | Condition flags |

## Verification
The assertions assume that every request field and the register read data are known values whenever `in_valid` is high. They also assume that the register file answers a read address in the same cycle, so the operand captured with a request matches the addresses it drove. The stimulus holds each field steady for a whole cycle and keeps operation codes within 0 to 4. It biases register indices toward 31, so that every aliasing case is reached. It also puts corner values such as the most negative number, all ones and zero into the register file, so that the carry and overflow edges are reached.

// File: rtl/alu_opflag_pkg.sv
package alu_opflag_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_ORR = 3'd3,
    OP_EOR = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    FM_IMM    = 2'd0,
    FM_SHREG  = 2'd1,
    FM_EXTREG = 2'd2
  } opnd_form_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic op_is_bitwise(input logic [2:0] op);
    return (op == OP_AND) || (op == OP_ORR) || (op == OP_EOR);
  endfunction

endpackage

// File: rtl/alu_src_alias.sv
module alu_src_alias
  import alu_opflag_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IDXW = 5
) (
  input  logic [2:0]      op,
  input  logic [1:0]      form,
  input  logic            set_flags,
  input  logic [IDXW-1:0] rn_idx,
  input  logic [IDXW-1:0] rm_idx,
  input  logic [IDXW-1:0] rd_idx,
  input  logic [XLEN-1:0] rn_rf,
  input  logic [XLEN-1:0] rm_rf,
  input  logic [XLEN-1:0] sp_val,
  output logic [XLEN-1:0] opnd_a,
  output logic [XLEN-1:0] rm_val,
  output logic            rd_is_gpr,
  output logic            rd_to_sp
);
  localparam logic [IDXW-1:0] ALIAS_IDX = '1;

  logic form_is_shreg;
  logic rn_hits_alias;
  logic rn_is_zr;
  logic rd_hits_alias;

  assign form_is_shreg = (form == FM_SHREG);
  assign rn_hits_alias = (rn_idx == ALIAS_IDX);
  assign rn_is_zr      = rn_hits_alias && (op_is_bitwise(op) || form_is_shreg);

  always_comb begin
    if (rn_is_zr)           opnd_a = '0;
    else if (rn_hits_alias) opnd_a = sp_val;
    else                    opnd_a = rn_rf;
  end

  assign rm_val = (rm_idx == ALIAS_IDX) ? '0 : rm_rf;

  assign rd_hits_alias = (rd_idx == ALIAS_IDX);
  assign rd_is_gpr     = !rd_hits_alias;
  assign rd_to_sp      = rd_hits_alias && !(set_flags || form_is_shreg);

endmodule

// File: rtl/alu_opnd_b.sv
module alu_opnd_b
  import alu_opflag_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int EXT_SH_MAX = 4,
  localparam int SHW       = $clog2(XLEN)
) (
  input  logic [1:0]      form,
  input  logic [XLEN-1:0] rm_val,
  input  logic [XLEN-1:0] imm,
  input  logic [1:0]      shift_type,
  input  logic [SHW-1:0]  shift_amt,
  input  logic [2:0]      ext_type,
  input  logic [2:0]      ext_shift,
  output logic [XLEN-1:0] opnd_b
);

  function automatic logic [XLEN-1:0] shift_val(input logic [XLEN-1:0] v,
                                                input logic [1:0] kind,
                                                input logic [SHW-1:0] n);
    logic [2*XLEN-1:0] dbl;
    case (kind)
      SH_LSL:  return v << n;
      SH_LSR:  return v >> n;
      SH_ASR:  return $signed(v) >>> n;
      default: begin
        dbl = {v, v} >> n;
        return dbl[XLEN-1:0];
      end
    endcase
  endfunction

  function automatic logic [XLEN-1:0] extend_val(input logic [XLEN-1:0] v,
                                                 input logic [2:0] kind);
    logic [XLEN-1:0] r;
    int w;
    w = 8 << kind[1:0];
    if (w > XLEN) w = XLEN;
    for (int i = 0; i < XLEN; i++)
      r[i] = (i < w) ? v[i] : (kind[2] & v[w-1]);
    return r;
  endfunction

  logic [XLEN-1:0] shreg_val;
  logic [XLEN-1:0] ext_raw;
  logic [XLEN-1:0] extreg_val;
  logic [2:0]      ext_sh_eff;

  assign shreg_val  = shift_val(rm_val, shift_type, shift_amt);
  assign ext_raw    = extend_val(rm_val, ext_type);
  assign ext_sh_eff = (ext_shift > 3'(EXT_SH_MAX)) ? 3'(EXT_SH_MAX) : ext_shift;
  assign extreg_val = ext_raw << ext_sh_eff;

  always_comb begin
    case (form)
      FM_SHREG:  opnd_b = shreg_val;
      FM_EXTREG: opnd_b = extreg_val;
      default:   opnd_b = imm;
    endcase
  end

endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_opflag_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] result,
  output logic [3:0]      flags_calc
);

  function automatic logic add_carry(input logic [XLEN-1:0] s, input logic [XLEN-1:0] x);
    return s < x;
  endfunction

  function automatic logic add_ovf(input logic [XLEN-1:0] s, input logic [XLEN-1:0] x,
                                   input logic [XLEN-1:0] y);
    logic [XLEN-1:0] t;
    t = (s ^ x) & ~(x ^ y);
    return t[XLEN-1];
  endfunction

  function automatic logic sub_ovf(input logic [XLEN-1:0] d, input logic [XLEN-1:0] x,
                                   input logic [XLEN-1:0] y);
    logic [XLEN-1:0] t;
    t = (d ^ x) & (x ^ y);
    return t[XLEN-1];
  endfunction

  logic [XLEN-1:0] sum_w;
  logic [XLEN-1:0] diff_w;
  logic            carry_w;
  logic            ovf_w;
  nzcv_t           f;

  assign sum_w  = a + b;
  assign diff_w = a - b;

  always_comb begin
    case (op)
      OP_SUB: begin
        result  = diff_w;
        carry_w = !(a < b);
        ovf_w   = sub_ovf(diff_w, a, b);
      end
      OP_AND: begin result = a & b; carry_w = 1'b0; ovf_w = 1'b0; end
      OP_ORR: begin result = a | b; carry_w = 1'b0; ovf_w = 1'b0; end
      OP_EOR: begin result = a ^ b; carry_w = 1'b0; ovf_w = 1'b0; end
      default: begin
        result  = sum_w;
        carry_w = add_carry(sum_w, a);
        ovf_w   = add_ovf(sum_w, a, b);
      end
    endcase
  end

  always_comb begin
    f.n = result[XLEN-1];
    f.z = (result == '0);
    f.c = carry_w;
    f.v = ovf_w;
  end

  assign flags_calc = f;

endmodule

// File: rtl/alu_opflag_unit.sv
module alu_opflag_unit
  import alu_opflag_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int IDXW       = 5,
  parameter int EXT_SH_MAX = 4,
  localparam int SHW       = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      in_op,
  input  logic [1:0]      in_form,
  input  logic            in_setflags,
  input  logic [IDXW-1:0] in_rn_idx,
  input  logic [IDXW-1:0] in_rm_idx,
  input  logic [IDXW-1:0] in_rd_idx,
  input  logic [XLEN-1:0] in_imm,
  input  logic [1:0]      in_shift_type,
  input  logic [SHW-1:0]  in_shift_amt,
  input  logic [2:0]      in_ext_type,
  input  logic [2:0]      in_ext_shift,
  output logic [IDXW-1:0] rf_rn_addr,
  input  logic [XLEN-1:0] rf_rn_data,
  output logic [IDXW-1:0] rf_rm_addr,
  input  logic [XLEN-1:0] rf_rm_data,
  input  logic [XLEN-1:0] sp_rd_data,
  output logic            rf_wr_en,
  output logic [IDXW-1:0] rf_wr_addr,
  output logic [XLEN-1:0] rf_wr_data,
  output logic            sp_wr_en,
  output logic [XLEN-1:0] sp_wr_data,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic [3:0]      flags_nzcv
);

  logic [XLEN-1:0] opnd_a;
  logic [XLEN-1:0] rm_val;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] exec_result;
  logic [3:0]      exec_flags;
  logic            rd_is_gpr;
  logic            rd_to_sp;
  logic            flag_update;

  assign rf_rn_addr = in_rn_idx;
  assign rf_rm_addr = in_rm_idx;

  alu_src_alias #(.XLEN(XLEN), .IDXW(IDXW)) u_alias (
    .op        (in_op),
    .form      (in_form),
    .set_flags (in_setflags),
    .rn_idx    (in_rn_idx),
    .rm_idx    (in_rm_idx),
    .rd_idx    (in_rd_idx),
    .rn_rf     (rf_rn_data),
    .rm_rf     (rf_rm_data),
    .sp_val    (sp_rd_data),
    .opnd_a    (opnd_a),
    .rm_val    (rm_val),
    .rd_is_gpr (rd_is_gpr),
    .rd_to_sp  (rd_to_sp)
  );

  alu_opnd_b #(.XLEN(XLEN), .EXT_SH_MAX(EXT_SH_MAX)) u_opnd_b (
    .form       (in_form),
    .rm_val     (rm_val),
    .imm        (in_imm),
    .shift_type (in_shift_type),
    .shift_amt  (in_shift_amt),
    .ext_type   (in_ext_type),
    .ext_shift  (in_ext_shift),
    .opnd_b     (opnd_b)
  );

  alu_exec #(.XLEN(XLEN)) u_exec (
    .op         (in_op),
    .a          (opnd_a),
    .b          (opnd_b),
    .result     (exec_result),
    .flags_calc (exec_flags)
  );

  assign flag_update = in_valid && in_setflags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      rf_wr_en   <= 1'b0;
      rf_wr_addr <= '0;
      rf_wr_data <= '0;
      sp_wr_en   <= 1'b0;
      sp_wr_data <= '0;
      flags_nzcv <= '0;
    end else begin
      out_valid <= in_valid;
      rf_wr_en  <= in_valid && rd_is_gpr;
      sp_wr_en  <= in_valid && rd_to_sp;
      if (in_valid) begin
        out_result <= exec_result;
        rf_wr_addr <= in_rd_idx;
        rf_wr_data <= exec_result;
        sp_wr_data <= exec_result;
      end
      if (flag_update) flags_nzcv <= exec_flags;
    end
  end

endmodule

// File: rtl/alu_opflag_chk.sv
module alu_opflag_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_setflags,
  input logic [2:0]      in_op,
  input logic [XLEN-1:0] opnd_a,
  input logic            out_valid,
  input logic [XLEN-1:0] out_result,
  input logic [3:0]      flags_nzcv,
  input logic            rf_wr_en,
  input logic            sp_wr_en
);

  a_r12_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !rf_wr_en && !sp_wr_en));

  a_r12_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_setflags) |=> $stable(flags_nzcv));

  a_r10_nz_track: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_setflags) |=>
      (flags_nzcv[3] == out_result[XLEN-1]) && (flags_nzcv[2] == (out_result == '0)));

  a_r11_logic_cv_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_setflags && (in_op inside {3'd2, 3'd3, 3'd4})) |=> (flags_nzcv[1:0] == 2'b00));

  a_r8_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_setflags && in_op == 3'd0) |=> (flags_nzcv[1] == (out_result < $past(opnd_a))));

  a_r6_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> !sp_wr_en);

  a_r6_flagset_no_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_setflags) |=> !sp_wr_en);

endmodule

bind alu_opflag_unit alu_opflag_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_setflags (in_setflags),
  .in_op       (in_op),
  .opnd_a      (opnd_a),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .flags_nzcv  (flags_nzcv),
  .rf_wr_en    (rf_wr_en),
  .sp_wr_en    (sp_wr_en)
);

// File: tb/alu_opflag_unit_tb.sv
module alu_opflag_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_form = '0;
  logic        in_setflags = 1'b0;
  logic [4:0]  in_rn_idx = '0, in_rm_idx = '0, in_rd_idx = '0;
  logic [63:0] in_imm = '0;
  logic [1:0]  in_shift_type = '0;
  logic [5:0]  in_shift_amt = '0;
  logic [2:0]  in_ext_type = '0, in_ext_shift = '0;
  logic [4:0]  rf_rn_addr, rf_rm_addr, rf_wr_addr;
  logic [63:0] rf_rn_data, rf_rm_data, rf_wr_data, sp_wr_data, out_result;
  logic [63:0] sp_rd_data = 64'h0000_7fff_0000_1000;
  logic        rf_wr_en, sp_wr_en, out_valid;
  logic [3:0]  flags_nzcv;

  logic [63:0] regs [32];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [3:0] exp_flags = 4'h0;

  always #2 clk = ~clk;

  assign rf_rn_data = regs[rf_rn_addr];
  assign rf_rm_data = regs[rf_rm_addr];

  alu_opflag_unit u_dut (.*);

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] m_shift(input logic [63:0] v, input logic [1:0] t, input int n);
    logic [63:0] fill;
    case (t)
      2'd0: return v << n;
      2'd1: return v >> n;
      2'd2: begin
        fill = v[63] ? ~(64'hffff_ffff_ffff_ffff >> n) : 64'h0;
        return (v >> n) | fill;
      end
      default: return (n == 0) ? v : ((v >> n) | (v << (64 - n)));
    endcase
  endfunction

  function automatic logic [63:0] m_extend(input logic [63:0] v, input logic [2:0] k);
    case (k)
      3'd0: return {56'h0, v[7:0]};
      3'd1: return {48'h0, v[15:0]};
      3'd2: return {32'h0, v[31:0]};
      3'd4: return {{56{v[7]}}, v[7:0]};
      3'd5: return {{48{v[15]}}, v[15:0]};
      3'd6: return {{32{v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  task automatic run_op(input string tag, input logic [2:0] op, input logic [1:0] fm,
                        input logic sf, input logic [4:0] rn, input logic [4:0] rm,
                        input logic [4:0] rd, input logic [63:0] imm, input logic [1:0] st,
                        input logic [5:0] sa, input logic [2:0] et, input logic [2:0] es);
    logic [63:0] a, b, rmv, r;
    logic [64:0] wide;
    logic c, v, zr_rn, logic_op, to_sp;
    int esh;
    logic_op = (op >= 3'd2) && (op <= 3'd4);
    zr_rn = logic_op || (fm == 2'd1);
    if (rn != 5'd31) a = regs[rn];
    else a = zr_rn ? 64'h0 : sp_rd_data;
    rmv = (rm == 5'd31) ? 64'h0 : regs[rm];
    esh = (es > 3'd4) ? 4 : int'(es);
    case (fm)
      2'd1: b = m_shift(rmv, st, int'(sa));
      2'd2: b = m_extend(rmv, et) << esh;
      default: b = imm;
    endcase
    c = 1'b0; v = 1'b0;
    case (op)
      3'd1: begin
        r = a + (~b) + 64'd1;
        c = (a >= b);
        v = (a[63] != b[63]) && (r[63] != a[63]);
      end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      default: begin
        wide = {1'b0, a} + {1'b0, b};
        r = wide[63:0];
        c = wide[64];
        v = (a[63] == b[63]) && (r[63] != a[63]);
      end
    endcase
    if (sf) exp_flags = {r[63], r == 64'h0, c, v};
    to_sp = (rd == 5'd31) && !sf && (fm != 2'd1);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_form = fm; in_setflags = sf;
    in_rn_idx = rn; in_rm_idx = rm; in_rd_idx = rd; in_imm = imm;
    in_shift_type = st; in_shift_amt = sa; in_ext_type = et; in_ext_shift = es;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, {63'h0, out_valid}, 64'h1);
    chk({tag, " result"}, out_result, r);
    chk({tag, " flags"}, {60'h0, flags_nzcv}, {60'h0, exp_flags});
    chk({tag, " gpr write"}, {63'h0, rf_wr_en}, {63'h0, rd != 5'd31});
    chk({tag, " sp write"}, {63'h0, sp_wr_en}, {63'h0, to_sp});
    if (rd != 5'd31) begin
      chk({tag, " wr addr"}, {59'h0, rf_wr_addr}, {59'h0, rd});
      chk({tag, " wr data"}, rf_wr_data, r);
    end
    if (to_sp) chk({tag, " sp data"}, sp_wr_data, r);
  endtask

  function automatic logic [63:0] pick_val();
    case ($urandom_range(0, 7))
      0: return 64'h8000_0000_0000_0000;
      1: return 64'h7fff_ffff_ffff_ffff;
      2: return 64'hffff_ffff_ffff_ffff;
      3: return 64'h0;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  function automatic logic [4:0] pick_idx();
    return ($urandom_range(0, 3) == 0) ? 5'd31 : 5'($urandom_range(0, 30));
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 31; i++) regs[i] = {$urandom(), $urandom()};
    regs[31] = 64'hdead_beef_cafe_f00d;
    regs[1] = 64'h7fff_ffff_ffff_ffff;
    regs[2] = 64'hffff_ffff_ffff_ffff;
    regs[3] = 64'h8000_0000_0000_0000;
    regs[4] = 64'h0000_0000_0000_0001;
    regs[5] = 64'h0000_0000_8000_00f0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 out_valid", {63'h0, out_valid}, 64'h0);
    chk("R13 flags", {60'h0, flags_nzcv}, 64'h0);
    chk("R13 writes", {62'h0, rf_wr_en, sp_wr_en}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op("R1", 3'd0, 2'd0, 1'b0, 5'd4, 5'd0, 5'd7, 64'h123, 2'd0, 6'd0, 3'd0, 3'd0);
    run_op("R1", 3'd3, 2'd3, 1'b0, 5'd4, 5'd0, 5'd8, 64'hf0, 2'd0, 6'd0, 3'd0, 3'd0);
    run_op("R8", 3'd0, 2'd0, 1'b1, 5'd1, 5'd0, 5'd9, 64'h1, 2'd0, 6'd0, 3'd0, 3'd0);
    run_op("R8", 3'd0, 2'd0, 1'b1, 5'd2, 5'd0, 5'd9, 64'h1, 2'd0, 6'd0, 3'd0, 3'd0);
    run_op("R12", 3'd0, 2'd0, 1'b0, 5'd4, 5'd0, 5'd9, 64'h5, 2'd0, 6'd0, 3'd0, 3'd0);
    run_op("R9", 3'd1, 2'd1, 1'b1, 5'd4, 5'd4, 5'd10, 64'h0, 2'd0, 6'd0, 3'd0, 3'd0);
    run_op("R9", 3'd1, 2'd1, 1'b1, 5'd31, 5'd4, 5'd10, 64'h0, 2'd0, 6'd0, 3'd0, 3'd0);
    run_op("R9", 3'd1, 2'd0, 1'b1, 5'd3, 5'd0, 5'd10, 64'h1, 2'd0, 6'd0, 3'd0, 3'd0);
    run_op("R10", 3'd2, 2'd1, 1'b1, 5'd3, 5'd2, 5'd11, 64'h0, 2'd0, 6'd0, 3'd0, 3'd0);
    run_op("R11", 3'd0, 2'd0, 1'b1, 5'd3, 5'd0, 5'd9, 64'h8000_0000_0000_0000, 2'd0, 6'd0, 3'd0, 3'd0);
    run_op("R11", 3'd4, 2'd0, 1'b1, 5'd2, 5'd0, 5'd11, 64'h0f, 2'd0, 6'd0, 3'd0, 3'd0);
    run_op("R2", 3'd3, 2'd1, 1'b0, 5'd31, 5'd5, 5'd12, 64'h0, 2'd0, 6'd63, 3'd0, 3'd0);
    run_op("R2", 3'd3, 2'd1, 1'b0, 5'd31, 5'd3, 5'd12, 64'h0, 2'd2, 6'd7, 3'd0, 3'd0);
    run_op("R2", 3'd3, 2'd1, 1'b0, 5'd31, 5'd5, 5'd12, 64'h0, 2'd3, 6'd4, 3'd0, 3'd0);
    run_op("R2", 3'd3, 2'd1, 1'b0, 5'd31, 5'd3, 5'd12, 64'h0, 2'd1, 6'd60, 3'd0, 3'd0);
    run_op("R3", 3'd0, 2'd2, 1'b0, 5'd4, 5'd5, 5'd13, 64'h0, 2'd0, 6'd0, 3'd6, 3'd2);
    run_op("R3", 3'd0, 2'd2, 1'b0, 5'd4, 5'd5, 5'd13, 64'h0, 2'd0, 6'd0, 3'd4, 3'd7);
    run_op("R3", 3'd1, 2'd2, 1'b0, 5'd4, 5'd2, 5'd13, 64'h0, 2'd0, 6'd0, 3'd1, 3'd4);
    run_op("R4", 3'd0, 2'd2, 1'b0, 5'd31, 5'd4, 5'd14, 64'h0, 2'd0, 6'd0, 3'd3, 3'd0);
    run_op("R4", 3'd0, 2'd0, 1'b0, 5'd31, 5'd0, 5'd14, 64'h10, 2'd0, 6'd0, 3'd0, 3'd0);
    run_op("R4", 3'd3, 2'd0, 1'b0, 5'd31, 5'd0, 5'd14, 64'h10, 2'd0, 6'd0, 3'd0, 3'd0);
    run_op("R5", 3'd0, 2'd1, 1'b0, 5'd4, 5'd31, 5'd15, 64'h0, 2'd0, 6'd0, 3'd0, 3'd0);
    run_op("R5", 3'd0, 2'd2, 1'b0, 5'd4, 5'd31, 5'd15, 64'h0, 2'd0, 6'd0, 3'd3, 3'd1);
    run_op("R6", 3'd0, 2'd0, 1'b0, 5'd31, 5'd0, 5'd31, 64'h40, 2'd0, 6'd0, 3'd0, 3'd0);
    run_op("R6", 3'd0, 2'd0, 1'b1, 5'd31, 5'd0, 5'd31, 64'h40, 2'd0, 6'd0, 3'd0, 3'd0);
    run_op("R6", 3'd0, 2'd1, 1'b0, 5'd4, 5'd4, 5'd31, 64'h0, 2'd0, 6'd0, 3'd0, 3'd0);
    run_op("R7", 3'd2, 2'd0, 1'b0, 5'd2, 5'd0, 5'd16, 64'h00ff, 2'd0, 6'd0, 3'd0, 3'd0);

    // R12: an idle cycle leaves flags and strobes quiet
    @(negedge clk);
    chk("R12 idle valid", {63'h0, out_valid}, 64'h0);
    chk("R12 idle flags", {60'h0, flags_nzcv}, {60'h0, exp_flags});

    for (int k = 0; k < 400; k++) begin
      if (k % 16 == 0) for (int j = 1; j < 31; j++) regs[j] = pick_val();
      run_op("R7", 3'($urandom_range(0, 4)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
             pick_idx(), pick_idx(), pick_idx(), pick_val(), 2'($urandom_range(0, 3)),
             6'($urandom_range(0, 63)), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule